// File: doc/BRIEF.md
# DMA Transfer Count Register Set

A 24-bit transfer counter for a storage-bus controller, presented to software as three byte-wide registers. The registers have two copies. Byte writes land in write-side shadow copies. The live count is the copy that reads return and that the DMA engine consumes. A command whose DMA flag is set copies the shadows into the live count in one step. A command with the flag clear selects programmed I/O mode and leaves the live count alone.

The block gives the DMA engine an effective transfer length. A live count of zero stands for 65536 bytes. The length is clipped either to the remaining data size or to the command buffer size, depending on whether a command is being captured. The engine reports progress through a decrement strobe carrying a byte count and reports completion through a done strobe. Terminal count rises when the count runs out.

Until the high byte has been written once after reset, reads of it return a fixed identification byte. From then on they return the live high byte.

Top module: `xfer_count_regs`

## Requirements
- R1: After reset the low and middle bytes read 0x00 and the high byte reads CHIP_ID. Terminal count and DMA mode are both 0. The effective length is 0x10000, so xfer_len_o equals remain_i when remain_i is at most 0x10000.
- R2: Register writes go only to the shadow copies. Addresses are 0 for the low byte, 1 for the middle byte and 2 for the high byte. Reads of these addresses return the live bytes, which a write leaves unchanged. Address 3 reads 0x00 and a write to it has no effect.
- R3: A write to address 0, 1 or 2 clears tc_o on the next edge, unless a done or a decrement sets it in the same cycle.
- R4: A command with cmd_i bit 7 set loads live = shadow_low | shadow_mid<<8 | shadow_high<<16 and sets dma_mode_o to 1. A command with bit 7 clear sets dma_mode_o to 0 and leaves the live count unchanged.
- R5: The high byte reads CHIP_ID until the first write to address 2 after reset, and reads the live high byte after that. Only reset clears this written-once state.
- R6: The effective count is the live count when that count is nonzero, and 0x10000 when it is zero.
- R7: xfer_len_o is min(effective count, remain_i) when capture_i is 0. It is min(effective count, CMD_BUF_SZ) when capture_i is 1.
- R8: A decrement replaces the live count with (effective count - dec_bytes_i). tc_o rises on the same edge at which the live count becomes zero.
- R9: A done strobe zeroes all three live bytes and sets tc_o.
- R10: When done and a decrement arrive together, done wins and the live count ends at zero. Decrement and done both take priority over a count load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register select: 0 low, 1 middle, 2 high, 3 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command byte; bit 7 is the DMA flag |
| dec_valid_i | input | 1 | Decrement strobe from the DMA engine |
| dec_bytes_i | input | 24 | Bytes moved; no larger than the effective count |
| done_i | input | 1 | DMA completion strobe |
| capture_i | input | 1 | 1 when the transfer captures a command |
| remain_i | input | 24 | Remaining data size |
| xfer_len_o | output | 24 | Transfer length for the DMA engine |
| tc_o | output | 1 | Terminal count |
| dma_mode_o | output | 1 | 1 in DMA mode, 0 in programmed I/O mode |

## Verification
The bench checks that byte writes leave the live count untouched. A design that wired writes straight into the live count would show the written byte at once instead of the old value. It counts a zero live count down from 0x10000 to exact zero. A design that treated zero as zero would underflow, or would never raise terminal count. It also covers several edge cases. The identification byte must survive writes to the other bytes and must return after a reset. A done and a decrement in the same cycle must resolve in favour of done. A write to the unused address must leave terminal count set.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
  localparam int NUM_BYTES = 3;
  localparam int ADDR_W    = 2;
  typedef enum logic [ADDR_W-1:0] {
    XC_LOW  = 2'd0,
    XC_MID  = 2'd1,
    XC_HIGH = 2'd2,
    XC_NONE = 2'd3
  } xc_addr_e;
endpackage

// File: rtl/xcnt_shadow.sv
module xcnt_shadow
  import xcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  shadow_o,
  output logic              hi_written_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) shadow_o[g*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_written_o <= 1'b0;
    else if (we_i && addr_i == XC_HIGH) hi_written_o <= 1'b1;
  end
endmodule

// File: rtl/xcnt_live.sv
module xcnt_live
  import xcnt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ZERO_LEN = 65536,
  localparam int CNT_W   = NUM_BYTES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] shadow_i,
  input  logic             dec_valid_i,
  input  logic [CNT_W-1:0] dec_bytes_i,
  input  logic             done_i,
  input  logic             tc_clr_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] eff_o,
  output logic             tc_o,
  output logic             dma_mode_o
);
  logic [CNT_W-1:0] dec_next;
  logic             tc_set;

  assign eff_o    = (live_o == '0) ? CNT_W'(ZERO_LEN) : live_o;
  assign dec_next = eff_o - dec_bytes_i;
  assign tc_set   = done_i || (dec_valid_i && dec_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          live_o <= '0;
    else if (done_i)      live_o <= '0;
    else if (dec_valid_i) live_o <= dec_next;
    else if (load_i)      live_o <= shadow_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_o <= 1'b0;
    else if (tc_set)   tc_o <= 1'b1;
    else if (tc_clr_i) tc_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dma_mode_o <= 1'b0;
    else if (mode_we_i) dma_mode_o <= load_i;
  end
endmodule

// File: rtl/xcnt_len_sel.sv
module xcnt_len_sel #(
  parameter int CNT_W      = 24,
  parameter int CMD_BUF_SZ = 32
) (
  input  logic [CNT_W-1:0] eff_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] limit;
  assign limit = capture_i ? CNT_W'(CMD_BUF_SZ) : remain_i;
  assign len_o = (eff_i < limit) ? eff_i : limit;
endmodule

// File: rtl/xfer_count_regs.sv
module xfer_count_regs
  import xcnt_pkg::*;
#(
  parameter int          BYTE_W       = 8,
  parameter int          ZERO_LEN     = 65536,
  parameter int          CMD_BUF_SZ   = 32,
  parameter int          DMA_FLAG_BIT = 7,
  parameter logic [7:0]  CHIP_ID      = 8'hA2,
  localparam int         CNT_W        = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  input  logic              dec_valid_i,
  input  logic [CNT_W-1:0]  dec_bytes_i,
  input  logic              done_i,
  input  logic              capture_i,
  input  logic [CNT_W-1:0]  remain_i,
  output logic [CNT_W-1:0]  xfer_len_o,
  output logic              tc_o,
  output logic              dma_mode_o
);
  logic [CNT_W-1:0] shadow, live, eff;
  logic             hi_written, cnt_wr, load;

  assign cnt_wr = reg_we_i && (reg_addr_i != XC_NONE);
  assign load   = cmd_we_i && cmd_i[DMA_FLAG_BIT];

  xcnt_shadow #(.BYTE_W(BYTE_W)) u_shadow (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .shadow_o    (shadow),
    .hi_written_o(hi_written)
  );

  xcnt_live #(.BYTE_W(BYTE_W), .ZERO_LEN(ZERO_LEN)) u_live (
    .clk_i, .rst_ni,
    .mode_we_i  (cmd_we_i),
    .load_i     (load),
    .shadow_i   (shadow),
    .dec_valid_i,
    .dec_bytes_i,
    .done_i,
    .tc_clr_i   (cnt_wr),
    .live_o     (live),
    .eff_o      (eff),
    .tc_o,
    .dma_mode_o
  );

  xcnt_len_sel #(.CNT_W(CNT_W), .CMD_BUF_SZ(CMD_BUF_SZ)) u_len (
    .eff_i    (eff),
    .capture_i,
    .remain_i,
    .len_o    (xfer_len_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = live[i*BYTE_W +: BYTE_W];
    end
    // id byte until the high byte is first written
    if (reg_addr_i == XC_HIGH && !hi_written) reg_rdata_o = BYTE_W'(CHIP_ID);
  end
endmodule

// File: rtl/xfer_count_regs_chk.sv
module xfer_count_regs_chk #(
  parameter int         CNT_W        = 24,
  parameter int         CMD_BUF_SZ   = 32,
  parameter int         DMA_FLAG_BIT = 7,
  parameter logic [7:0] CHIP_ID      = 8'hA2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       reg_addr_i,
  input logic             reg_we_i,
  input logic [7:0]       reg_rdata_o,
  input logic             cmd_we_i,
  input logic [7:0]       cmd_i,
  input logic             dec_valid_i,
  input logic             done_i,
  input logic             capture_i,
  input logic [CNT_W-1:0] remain_i,
  input logic [CNT_W-1:0] xfer_len_o,
  input logic             tc_o,
  input logic             dma_mode_o
);
  logic seen_hi;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_hi <= 1'b0;
    else if (reg_we_i && reg_addr_i == 2'd2) seen_hi <= 1'b1;
  end

  // R3
  tc_clear_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i != 2'd3 && !done_i && !dec_valid_i) |=> !tc_o);

  // R9
  tc_set_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> tc_o);

  // R8
  tc_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> $past(done_i || dec_valid_i));

  // R4
  dma_mode_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[DMA_FLAG_BIT]) |=> dma_mode_o);

  // R4
  pio_mode_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_i[DMA_FLAG_BIT]) |=> !dma_mode_o);

  // R5
  chip_id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_hi && reg_addr_i == 2'd2) |-> reg_rdata_o == CHIP_ID);

  // R7
  len_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> (xfer_len_o <= CNT_W'(CMD_BUF_SZ) && xfer_len_o != '0));

  // R7
  len_remain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |-> xfer_len_o <= remain_i);
endmodule

bind xfer_count_regs xfer_count_regs_chk #(
  .CNT_W(CNT_W), .CMD_BUF_SZ(CMD_BUF_SZ), .DMA_FLAG_BIT(DMA_FLAG_BIT), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
  .reg_rdata_o(reg_rdata_o), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
  .dec_valid_i(dec_valid_i), .done_i(done_i), .capture_i(capture_i),
  .remain_i(remain_i), .xfer_len_o(xfer_len_o), .tc_o(tc_o), .dma_mode_o(dma_mode_o)
);

// File: tb/xfer_count_regs_test.sv
module xfer_count_regs_test;
  localparam int         CMD_SZ = 32;
  localparam logic [7:0] ID     = 8'hA2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        cmd_we_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic        dec_valid_i = 1'b0;
  logic [23:0] dec_bytes_i = '0;
  logic        done_i = 1'b0;
  logic        capture_i = 1'b0;
  logic [23:0] remain_i = 24'hFFFFFF;
  logic [23:0] xfer_len_o;
  logic        tc_o, dma_mode_o;

  xfer_count_regs uut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_sh[3];
  int m_lv, m_tc, m_mode, m_hiw;

  function automatic int m_eff();
    return (m_lv == 0) ? 65536 : m_lv;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_lv & 255;
      1: return (m_lv >> 8) & 255;
      2: return m_hiw ? ((m_lv >> 16) & 255) : int'(ID);
      default: return 0;
    endcase
  endfunction

  function automatic int m_len();
    int lim;
    lim = capture_i ? CMD_SZ : int'(remain_i);
    return (m_eff() < lim) ? m_eff() : lim;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_sh[i] = 0;
    m_lv = 0; m_tc = 0; m_mode = 0; m_hiw = 0;
  endtask

  task automatic model_edge();
    int nv;
    if (done_i) begin m_lv = 0; m_tc = 1; end
    else if (dec_valid_i) begin
      nv = m_eff() - int'(dec_bytes_i);
      m_lv = nv;
      if (nv == 0) m_tc = 1;
    end else if (cmd_we_i && cmd_i[7])
      m_lv = m_sh[0] | (m_sh[1] << 8) | (m_sh[2] << 16);
    if (reg_we_i && reg_addr_i != 2'd3) begin
      if (!(done_i || (dec_valid_i && m_lv == 0))) m_tc = 0;
    end
    if (reg_we_i && reg_addr_i != 2'd3) begin
      m_sh[reg_addr_i] = int'(reg_wdata_i);
      if (reg_addr_i == 2'd2) m_hiw = 1;
    end
    if (cmd_we_i) m_mode = cmd_i[7];
  endtask

  // inputs already driven; compare, then advance one clock
  task automatic step(string tag);
    #1;
    chk(tag, "rdata", int'(reg_rdata_o), m_read(int'(reg_addr_i)));
    chk(tag, "len", int'(xfer_len_o), m_len());
    chk(tag, "tc", int'(tc_o), m_tc);
    chk(tag, "mode", int'(dma_mode_o), m_mode);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    reg_we_i = 0; cmd_we_i = 0; dec_valid_i = 0; done_i = 0;
  endtask

  task automatic wr(int a, int d, string tag);
    reg_addr_i = 2'(a); reg_wdata_i = 8'(d); reg_we_i = 1; step(tag);
  endtask
  task automatic cmd(int c, string tag);
    cmd_i = 8'(c); cmd_we_i = 1; step(tag);
  endtask
  task automatic dec(int n, string tag);
    dec_bytes_i = 24'(n); dec_valid_i = 1; step(tag);
  endtask
  task automatic rd(int a, string tag);
    reg_addr_i = 2'(a); step(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0; model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state, zero count means 0x10000
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1");
    remain_i = 24'h010000; rd(3, "R1");
    remain_i = 24'hFFFFFF; rd(0, "R6");
    // R9 done sets tc, R3 write clears it
    done_i = 1; rd(0, "R9");
    rd(0, "R9");
    wr(0, 8'h34, "R3");
    // R2 shadow only
    rd(0, "R2");
    wr(1, 8'h12, "R2");
    rd(1, "R2"); rd(2, "R5");
    // R4 load with DMA flag
    cmd(8'h90, "R4");
    rd(0, "R4"); rd(1, "R4"); rd(2, "R5");
    // R6/R7 lengths
    remain_i = 24'h000100; rd(0, "R7");
    remain_i = 24'h00FFFF; rd(0, "R6");
    capture_i = 1; rd(0, "R7");
    capture_i = 0; remain_i = 24'hFFFFFF;
    // R5 first high write reveals live byte
    wr(2, 8'h01, "R5");
    rd(2, "R5");
    wr(3, 8'h55, "R2"); rd(3, "R2");
    // R4 PIO command leaves live alone
    cmd(8'h10, "R4"); rd(2, "R4");
    cmd(8'h90, "R4"); rd(2, "R4"); rd(0, "R6");
    // R8 decrement to zero
    dec(24'h001234, "R8"); rd(1, "R8");
    dec(24'h010000, "R8"); rd(0, "R8");
    rd(2, "R6");
    // R2 address 3 write leaves tc set
    wr(3, 8'hAA, "R2"); rd(0, "R2");
    // R10 done beats decrement
    wr(1, 8'h40, "R3"); cmd(8'h80, "R10"); rd(1, "R10");
    dec_bytes_i = 24'h000010; dec_valid_i = 1; done_i = 1; step("R10");
    rd(0, "R10"); rd(1, "R10"); rd(2, "R10");
    // R10 dec beats load in same cycle
    wr(0, 8'h77, "R3");
    cmd_i = 8'h80; cmd_we_i = 1; dec_bytes_i = 24'h000100; dec_valid_i = 1; step("R10");
    rd(0, "R10"); rd(1, "R10");
    // R5 reset clears written-once state; R8 count down from zero count
    do_reset();
    rd(2, "R5"); rd(0, "R1");
    cmd(8'h80, "R4");
    capture_i = 1; rd(0, "R7"); capture_i = 0;
    dec(24'h008000, "R8"); rd(1, "R8");
    dec(24'h008000, "R8"); rd(1, "R8"); rd(0, "R6");
    cmd(8'h00, "R4"); rd(0, "R4");
    summary();
  end
endmodule